// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block reduces a vector of per-element condition bits to one branch decision. After a start pulse it latches the vector length, the counter value, the condition and predicate vectors and the mode controls. It then walks the elements in ascending order, examining one element per clock cycle. Each examined element is either tested or skipped. The tested results are folded into a running all-pass (AND) or any-pass (OR) result. The walk stops at the first element whose result settles the outcome, so no later element is examined and no later element has side effects.

Along the way the unit can decrement a loop counter, chosen per element by pass, by fail or by skip. It can also cut the vector length at the element where the result matches a chosen polarity. When the walk ends it gives a single done pulse. With that pulse it reports whether the branch is taken, the truncated length if one was produced, the final counter value and whether the link register should be written. Target address generation, the counter zero test and condition-register reads are left to the surrounding pipeline.

Top module: `vbranch_eval`

## Requirements
- R1: The control `bo_i` has three bits. `bo_i[0]` forces every tested element to pass. `bo_i[1]` is the expected test-bit value. `bo_i[2]` set disables every counter decrement. A tested element passes when `bo_i[0]` is 1 or its test bit equals `bo_i[1]`.
- R2: `taken_o` is the AND of all tested results when `all_i`=1, and the OR when `all_i`=0. The fold starts from the identity value. So if no element is tested (VL=0, or every element skipped), the branch is taken in all-mode and not taken in any-mode.
- R3: The walk stops at the first failing tested element in all-mode, and at the first passing one in any-mode. Later elements cause no counter change. `done_o` rises one cycle after the last examined element. That is N cycles after the start edge when N elements were examined, and 1 cycle after it when VL=0.
- R4: For an element whose predicate bit is 0: with `sz_i`=1 the test bit is taken as `snz_i` and the element is tested normally. With `sz_i`=0 the element is skipped.
- R5: For tested elements, with `bo_i[2]`=0: if `ctr_test_i`=0 the counter decrements once per element. If `ctr_test_i`=1 and `cti_i`=0 it decrements only on a pass. If `ctr_test_i`=1 and `cti_i`=1 it decrements only on a fail.
- R6: A skipped element decrements the counter only when `bo_i[2]`=0, `ctr_test_i`=0 and `cti_i`=1. A skipped element never affects the result.
- R7: With `vlset_i`=1, a tested element whose result equals `vsb_i` ends the walk. It raises `vl_valid_o`. `new_vl_o` is set to index+1 when `vli_i`=1. The element's counter update still applies, and `taken_o` is the fold including that element.
- R8: With `vli_i`=0, `new_vl_o` is the element index minus the number of skipped elements directly before it. For example, with mask 110010 (element 0 on the right) and a fail at element 4, the value is 2. With `sz_i`=1 it is 4, and with `vli_i`=1 it is 5.
- R9: With `scalar_i`=1 the walk ends after the first tested element. Skipped elements before it are still walked.
- R10: `lr_update_o` is 1 only when `lk_i`=1, and then only if `lru_i`=0 or the branch is taken.
- R11: `start_i` is accepted only while idle. A start while busy changes neither the latched inputs nor the result. `done_o` is a single-cycle pulse.
- R12: After reset `busy_o`, `done_o`, `taken_o`, `vl_valid_o`, `new_vl_o`, `lr_update_o` and `ctr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new evaluation (ignored while busy) |
| vl_i | input | VL_W | Vector length, clamped to MAX_VL |
| ctr_i | input | CTR_W | Initial counter value |
| cond_i | input | MAX_VL | Selected condition bit per element |
| pred_i | input | MAX_VL | Predicate mask bit per element |
| bo_i | input | 3 | Unconditional, expected value, counter disable |
| all_i | input | 1 | 1: all must pass, 0: any pass |
| sz_i | input | 1 | Substitute instead of skipping masked elements |
| snz_i | input | 1 | Substitute test bit value |
| vlset_i | input | 1 | Enable length truncation |
| vsb_i | input | 1 | Result polarity that triggers truncation |
| vli_i | input | 1 | Truncated length includes the deciding element |
| ctr_test_i | input | 1 | Counter decrement depends on the test |
| cti_i | input | 1 | Invert the counter decrement condition |
| lk_i | input | 1 | Link register write requested |
| lru_i | input | 1 | Link write only when taken |
| scalar_i | input | 1 | Condition operand is scalar |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision |
| vl_valid_o | output | 1 | Truncation produced |
| new_vl_o | output | VL_W | Truncated vector length |
| ctr_o | output | CTR_W | Counter value |
| lr_update_o | output | 1 | Link register write strobe |

## Verification
The assertions watch properties that hold on every clock. The counter never moves by more than one per cycle and holds when decrements are disabled. The latched length stays frozen while a start arrives during a run. `done_o` stays a single pulse. A truncated length never exceeds the latched length. An empty vector yields the fold identity. The link strobe stays low without `lk_i`. The skipped-run counter never outgrows the element index.

Other properties depend on the whole sequence of elements, so only the bench scenarios can show them. These are the exact exit element, the counter total under each decrement rule and the truncation value after skipped runs. The bench compares completion timing every cycle against a behavioural model over directed and random mode mixes.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  typedef struct packed {
    logic [2:0] bo;
    logic       all;
    logic       sz;
    logic       snz;
    logic       vlset;
    logic       vsb;
    logic       vli;
    logic       ctr_test;
    logic       cti;
    logic       lk;
    logic       lru;
    logic       scalar;
  } vbr_mode_t;
endpackage

// File: rtl/vbr_elem.sv
module vbr_elem
  import vbr_pkg::*;
(
  input  vbr_mode_t mode_i,
  input  logic      pred_bit_i,
  input  logic      cond_bit_i,
  output logic      skip_o,
  output logic      ok_o,
  output logic      ctr_dec_o
);
  logic test_bit;

  always_comb begin
    skip_o    = ~pred_bit_i & ~mode_i.sz;
    test_bit  = pred_bit_i ? cond_bit_i : mode_i.snz;
    ok_o      = mode_i.bo[0] | ~(test_bit ^ mode_i.bo[1]);
    ctr_dec_o = 1'b0;
    if (!mode_i.bo[2]) begin
      if (skip_o)                ctr_dec_o = ~mode_i.ctr_test & mode_i.cti;
      else if (mode_i.ctr_test)  ctr_dec_o = ok_o ^ mode_i.cti;
      else                       ctr_dec_o = 1'b1;
    end
  end
endmodule

// File: rtl/vbr_ctr.sv
module vbr_ctr #(
  parameter int unsigned CTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CTR_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CTR_W-1:0] ctr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctr_o <= '0;
    else if (load_i) ctr_o <= load_val_i;
    else if (dec_i)  ctr_o <= ctr_o - CTR_W'(1);
  end

  p_ctr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (ctr_o == $past(ctr_o)) || (ctr_o == $past(ctr_o) - CTR_W'(1)));
endmodule

// File: rtl/vbr_trunc.sv
module vbr_trunc #(
  parameter int unsigned VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic            skip_i,
  input  logic            vli_i,
  input  logic [VL_W-1:0] idx_i,
  output logic [VL_W-1:0] cand_vl_o
);
  // consecutive skipped elements directly before idx_i
  logic [VL_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (clear_i) run_q <= '0;
    else if (step_i)  run_q <= skip_i ? run_q + VL_W'(1) : '0;
  end

  assign cand_vl_o = vli_i ? idx_i + VL_W'(1) : idx_i - run_q;

  p_run_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> run_q <= idx_i);
endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
  import vbr_pkg::*;
#(
  parameter  int unsigned MAX_VL = 64,
  parameter  int unsigned CTR_W  = 64,
  localparam int unsigned VL_W   = $clog2(MAX_VL + 1),
  localparam int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic [MAX_VL-1:0] cond_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [2:0]        bo_i,
  input  logic              all_i,
  input  logic              sz_i,
  input  logic              snz_i,
  input  logic              vlset_i,
  input  logic              vsb_i,
  input  logic              vli_i,
  input  logic              ctr_test_i,
  input  logic              cti_i,
  input  logic              lk_i,
  input  logic              lru_i,
  input  logic              scalar_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic              vl_valid_o,
  output logic [VL_W-1:0]   new_vl_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              lr_update_o
);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic              busy_q, acc_q;
  logic [VL_W-1:0]   idx_q, vl_q;
  logic [MAX_VL-1:0] cond_q, pred_q;
  vbr_mode_t         mode_q, mode_in;

  logic start_ok, in_range, elem_act, tested, last_elem;
  logic skip, ok, dec_raw, acc_next, acc_fin;
  logic trunc_hit, decisive, scalar_end, finish;
  logic [VL_W-1:0] cand_vl;

  assign mode_in = '{bo: bo_i, all: all_i, sz: sz_i, snz: snz_i, vlset: vlset_i,
                     vsb: vsb_i, vli: vli_i, ctr_test: ctr_test_i, cti: cti_i,
                     lk: lk_i, lru: lru_i, scalar: scalar_i};

  assign start_ok = start_i & ~busy_q;

  vbr_elem u_elem (
    .mode_i     (mode_q),
    .pred_bit_i (pred_q[idx_q[IDX_W-1:0]]),
    .cond_bit_i (cond_q[idx_q[IDX_W-1:0]]),
    .skip_o     (skip),
    .ok_o       (ok),
    .ctr_dec_o  (dec_raw)
  );

  always_comb begin
    in_range   = idx_q < vl_q;
    elem_act   = busy_q & in_range;
    tested     = elem_act & ~skip;
    last_elem  = (idx_q + VL_W'(1)) == vl_q;
    acc_next   = mode_q.all ? (acc_q & ok) : (acc_q | ok);
    acc_fin    = tested ? acc_next : acc_q;
    trunc_hit  = tested & mode_q.vlset & (ok == mode_q.vsb);
    decisive   = tested & (mode_q.all ? ~ok : ok);
    scalar_end = tested & mode_q.scalar;
    finish     = busy_q & (~in_range | trunc_hit | decisive | scalar_end | last_elem);
  end

  vbr_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_ok),
    .load_val_i (ctr_i),
    .dec_i      (elem_act & dec_raw),
    .ctr_o      (ctr_o)
  );

  vbr_trunc #(.VL_W(VL_W)) u_trunc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_ok),
    .step_i    (elem_act),
    .skip_i    (skip),
    .vli_i     (mode_q.vli),
    .idx_i     (idx_q),
    .cand_vl_o (cand_vl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      acc_q       <= 1'b0;
      idx_q       <= '0;
      vl_q        <= '0;
      cond_q      <= '0;
      pred_q      <= '0;
      mode_q      <= '0;
      done_o      <= 1'b0;
      taken_o     <= 1'b0;
      vl_valid_o  <= 1'b0;
      new_vl_o    <= '0;
      lr_update_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        acc_q  <= all_i;  // fold identity
        idx_q  <= '0;
        vl_q   <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
        cond_q <= cond_i;
        pred_q <= pred_i;
        mode_q <= mode_in;
      end else if (busy_q) begin
        if (tested) acc_q <= acc_next;
        if (finish) begin
          busy_q      <= 1'b0;
          done_o      <= 1'b1;
          taken_o     <= acc_fin;
          vl_valid_o  <= trunc_hit;
          new_vl_o    <= trunc_hit ? cand_vl : '0;
          lr_update_o <= mode_q.lk & (~mode_q.lru | acc_fin);
        end else begin
          idx_q <= idx_q + VL_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(vl_q) && $stable(mode_q));
  p_ctr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mode_q.bo[2] |=> $stable(ctr_o));
  p_ctr_one_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (ctr_o == $past(ctr_o)) || (ctr_o == $past(ctr_o) - CTR_W'(1)));
  p_vl_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && vl_valid_o |-> new_vl_o <= vl_q);
  p_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (vl_q == '0) |-> taken_o == mode_q.all);
  p_lr_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !mode_q.lk |-> !lr_update_o);
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (vl_q != '0) |-> idx_q < vl_q);
endmodule

// File: tb/vbranch_eval_bench.sv
module vbranch_eval_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] bo;
    logic all, sz, snz, vlset, vsb, vli, ct, cti, lk, lru, sc;
  } mode_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [63:0] ctr_i = '0, cond_i = '0, pred_i = '0;
  mode_t       m_i = '0;
  logic        busy_o, done_o, taken_o, vl_valid_o, lr_update_o;
  logic [6:0]  new_vl_o;
  logic [63:0] ctr_o;

  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbranch_eval u_vbranch_eval (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vl_i(vl_i), .ctr_i(ctr_i),
    .cond_i(cond_i), .pred_i(pred_i), .bo_i(m_i.bo), .all_i(m_i.all),
    .sz_i(m_i.sz), .snz_i(m_i.snz), .vlset_i(m_i.vlset), .vsb_i(m_i.vsb),
    .vli_i(m_i.vli), .ctr_test_i(m_i.ct), .cti_i(m_i.cti), .lk_i(m_i.lk),
    .lru_i(m_i.lru), .scalar_i(m_i.sc), .busy_o(busy_o), .done_o(done_o),
    .taken_o(taken_o), .vl_valid_o(vl_valid_o), .new_vl_o(new_vl_o),
    .ctr_o(ctr_o), .lr_update_o(lr_update_o));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic mode_t mk(input logic [2:0] bo, input bit all, sz, snz, vlset, vsb, vli,
                               ct, cti, lk, lru, sc);
    mode_t r;
    r.bo = bo; r.all = all; r.sz = sz; r.snz = snz; r.vlset = vlset; r.vsb = vsb;
    r.vli = vli; r.ct = ct; r.cti = cti; r.lk = lk; r.lru = lru; r.sc = sc;
    return r;
  endfunction

  task automatic model(input int vl, input logic [63:0] cond, pred, ctr0, input mode_t m,
                       output bit tk, output bit vv, output int nv, output logic [63:0] ctr,
                       output bit lr, output int n);
    bit acc, t, ok;
    int run, visited;
    acc = m.all; ctr = ctr0; vv = 0; nv = 0; run = 0; visited = 0;
    for (int j = 0; j < vl; j++) begin
      visited = j + 1;
      if (pred[j]) t = cond[j];
      else if (!m.sz) begin
        if (!m.bo[2] && !m.ct && m.cti) ctr = ctr - 1;
        run++;
        continue;
      end else t = m.snz;
      ok = m.bo[0] || (t == m.bo[1]);
      if (!m.bo[2] && (m.ct ? (ok != m.cti) : 1'b1)) ctr = ctr - 1;
      acc = m.all ? (acc && ok) : (acc || ok);
      if (m.vlset && ok == m.vsb) begin
        vv = 1; nv = m.vli ? j + 1 : j - run;
        break;
      end
      if (m.all ? !ok : ok) break;
      if (m.sc) break;
      run = 0;
    end
    tk = acc;
    lr = m.lk && (!m.lru || acc);
    n = (visited == 0) ? 1 : visited;
  endtask

  task automatic run_case(input string tag, input int vl, input logic [63:0] cond, pred,
                          ctr0, input mode_t m, input bit poke);
    bit tk, vv, lr;
    int nv, n;
    logic [63:0] ec;
    model(vl, cond, pred, ctr0, m, tk, vv, nv, ec, lr, n);
    @(negedge clk);
    vl_i = 7'(vl); cond_i = cond; pred_i = pred; ctr_i = ctr0; m_i = m; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 1; c <= 200; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag, "done timing", 64'(done_o), 64'(c == n));
      if (c == n || done_o) begin
        chk(tag, "taken", 64'(taken_o), 64'(tk));
        chk(tag, "vl_valid", 64'(vl_valid_o), 64'(vv));
        chk(tag, "new_vl", 64'(new_vl_o), 64'(vv ? nv : 0));
        chk(tag, "ctr", ctr_o, ec);
        chk(tag, "lr_update", 64'(lr_update_o), 64'(lr));
        break;
      end
      if (poke && c == 1) begin
        start_i = 1'b1; vl_i = 7'd1; cond_i = ~cond; pred_i = ~pred; ctr_i = ~ctr0; m_i = ~m;
      end else if (poke && c == 2) start_i = 1'b0;
    end
    @(negedge clk);
    chk(tag, "done single pulse", 64'(done_o), 64'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "busy", 64'(busy_o), 0);
    chk("R12", "done", 64'(done_o), 0);
    chk("R12", "taken", 64'(taken_o), 0);
    chk("R12", "vl_valid/new_vl", {vl_valid_o, new_vl_o}, 0);
    chk("R12", "ctr", ctr_o, 0);
    chk("R12", "lr", 64'(lr_update_o), 0);
    rst_n = 1'b1;

    // args: bo all sz snz vlset vsb vli ct cti lk lru sc
    run_case("R1", 4, 64'b0100, '1, 100, mk(3'b010,0,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R1", 4, 64'b0000, '1, 100, mk(3'b001,0,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R2", 4, 64'b1111, '1, 100, mk(3'b010,1,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R2", 0, '1, '1, 7, mk(3'b010,1,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R2", 0, '1, '1, 7, mk(3'b010,0,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R2", 4, '1, '0, 7, mk(3'b010,1,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R3", 6, 64'b111011, '1, 50, mk(3'b010,1,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R4", 4, 64'b0001, 64'b0101, 50, mk(3'b010,1,1,1,0,0,0,0,0,0,0,0), 0);
    run_case("R4", 4, 64'b0001, 64'b0101, 50, mk(3'b010,1,1,0,0,0,0,0,0,0,0,0), 0);
    run_case("R4", 4, 64'b0101, 64'b0101, 50, mk(3'b010,1,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R5", 6, 64'b000111, '1, 20, mk(3'b010,1,0,0,0,0,0,1,0,0,0,0), 0);
    run_case("R5", 6, 64'b001000, '1, 20, mk(3'b010,0,0,0,0,0,0,1,1,0,0,0), 0);
    run_case("R5", 6, 64'b111111, '1, 20, mk(3'b110,1,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R6", 4, 64'b0000, 64'b1010, 20, mk(3'b010,0,0,0,0,0,0,0,1,0,0,0), 0);
    run_case("R6", 4, 64'b0000, 64'b1010, 20, mk(3'b010,0,0,0,0,0,0,1,1,0,0,0), 0);
    run_case("R7", 6, 64'b000011, '1, 9, mk(3'b010,1,0,0,1,0,1,0,0,0,0,0), 0);
    run_case("R7", 6, 64'b000100, '1, 9, mk(3'b010,0,0,0,1,1,0,0,0,0,0,0), 0);
    run_case("R8", 6, 64'b100010, 64'b110010, 9, mk(3'b010,1,0,0,1,0,0,0,0,0,0,0), 0);
    run_case("R8", 6, 64'b100010, 64'b110010, 9, mk(3'b010,1,1,1,1,0,0,0,0,0,0,0), 0);
    run_case("R8", 6, 64'b100010, 64'b110010, 9, mk(3'b010,1,0,0,1,0,1,0,0,0,0,0), 0);
    run_case("R9", 6, 64'b000000, 64'b000100, 9, mk(3'b010,0,0,0,0,0,0,0,0,0,0,1), 0);
    run_case("R10", 4, 64'b0000, '1, 9, mk(3'b010,0,0,0,0,0,0,0,0,1,1,0), 0);
    run_case("R10", 4, 64'b0000, '1, 9, mk(3'b010,0,0,0,0,0,0,0,0,1,0,0), 0);
    run_case("R10", 4, 64'b0010, '1, 9, mk(3'b010,0,0,0,0,0,0,0,0,1,1,0), 0);
    run_case("R10", 4, 64'b0010, '1, 9, mk(3'b010,0,0,0,0,0,0,0,0,0,0,0), 0);
    run_case("R11", 8, 64'hff, '1, 30, mk(3'b010,1,0,0,0,0,0,0,0,1,0,0), 1);
    run_case("R11", 64, '1, '1, 200, mk(3'b010,1,0,0,0,0,0,0,0,0,0,0), 0);

    for (int k = 0; k < 60; k++) begin
      mode_t rm;
      rm = mode_t'($urandom);
      run_case("R3", $urandom_range(0, 64), {$urandom, $urandom}, {$urandom, $urandom},
               64'($urandom), rm, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule